// File: doc/BRIEF.md
# Crypto engine command queue sequencer

The host feeds this block 32-bit command words through a single write port. Each word lands in a small inbound queue. A sequencer takes the words from the head of the queue in order and drives a reduced model of a cipher engine. There are five command kinds:

- DMA setup: captures the source address.
- Block start: runs the engine for a counted number of 16-byte blocks.
- DMA-complete marker.
- Memory copy: moves words between external memory and the internal RAM.
- Table load: places the current internal-RAM key image into one of eight key slots.

No cipher arithmetic and no external memory are modelled. A block costs a fixed number of cycles, and a copy costs one cycle per word.

The host polls three status flags: engine busy, queue empty and copy busy. It can also use a sticky interrupt status vector, which is gated by an enable mask into a single interrupt line. Error events raise their own status bits. There are two: a write into a full queue, and a table load aimed at the secure key slot, which the host may never touch. Some commands take a trailing address word. The sequencer consumes that word from the queue as the next entry after the opcode word.

Top module: `crypt_cmdq_seq`

## Requirements
- R1: After reset the queue is empty, engine busy and copy busy are 0, the interrupt status is 0, the interrupt line is low, the source address reads 0 and every key slot reads 0.
- R2: A word with bits 31:26 = 0x10 (DMA setup) makes the next queued word the source address, shown on `src_addr_o`.
- R3: A word with bits 31:26 = 0x0E (block start) whose bits 11:0 hold n keeps engine busy high for exactly (n+1)*11 consecutive cycles.
- R4: When engine busy falls, interrupt status bit 0 (engine done) is set.
- R5: Status bits are sticky. A write on the clear port clears each status bit whose data bit is 1, so 0xFF clears all of them. `irq_o` is high exactly when some status bit is set together with its enable bit, and 0x33 enables bits 0, 1, 4 and 5.
- R6: A word with bits 31:26 = 0x11 sets interrupt status bit 1 (DMA complete marker).
- R7: A word with bits 31:26 = 0x22 (memory copy) is followed by one address word. Bits 24:12 give the word count w, and copy busy is high for max(w,1) cycles. With bit 25 = 0 (inbound), the address becomes the internal-RAM key image at the end of the copy. With bit 25 = 1 (outbound), the image is left unchanged.
- R8: A word with bits 31:26 = 0x15 (table load) carries the table select in bits 25:24, the RAM select in bit 23, and the key table id in bits 20:17 (0x8 OR slot number). When the table select is 3, the key image is written into the slot. Any other table select leaves every slot unchanged.
- R9: A table load to slot 4 leaves that slot unchanged and sets interrupt status bit 5. Slot 4 always reads 0.
- R10: The queue holds 5 words. A write while it holds 5 is dropped and sets interrupt status bit 4.
- R11: Queued commands wait in order while the engine or a copy is busy. `q_empty_o` is low while any word is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 32 | Command or address word |
| irq_clr_we_i | input | 1 | Interrupt status clear strobe |
| irq_clr_i | input | 8 | Write-one-to-clear mask |
| irq_en_we_i | input | 1 | Interrupt enable write strobe |
| irq_en_i | input | 8 | Interrupt enable value |
| slot_rd_idx_i | input | 3 | Key slot readback select |
| eng_busy_o | output | 1 | Engine processing blocks |
| q_empty_o | output | 1 | Inbound queue empty |
| dma_busy_o | output | 1 | Memory copy in progress |
| irq_stat_o | output | 8 | Sticky interrupt status |
| irq_o | output | 1 | Enabled interrupt pending |
| src_addr_o | output | 32 | Source address from the last DMA setup |
| slot_rd_data_o | output | 32 | Selected key slot content |

## Verification
The hardest state to reach is a full queue with the sequencer stalled behind a running engine. Only there can an extra write overflow, and only there can commands be seen waiting with their effects withheld. The stimulus starts a 64-block run, which keeps the engine busy for 704 cycles. It then writes six words back to back, so the sixth is dropped, and checks that the queued DMA setup has not yet changed the source address. Random block counts, copy lengths and slot numbers from a fixed seed exercise the ordinary paths around this directed case.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int OPC_LSB = 26;
  localparam int OPC_W   = 6;
  localparam int IRQ_W   = 8;

  localparam logic [OPC_W-1:0] OP_START     = 6'h0E;
  localparam logic [OPC_W-1:0] OP_DMA_SETUP = 6'h10;
  localparam logic [OPC_W-1:0] OP_DMA_DONE  = 6'h11;
  localparam logic [OPC_W-1:0] OP_TABLE     = 6'h15;
  localparam logic [OPC_W-1:0] OP_COPY      = 6'h22;

  localparam int IRQ_DONE = 0;
  localparam int IRQ_DMAC = 1;
  localparam int IRQ_OVF  = 4;
  localparam int IRQ_SEC  = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_COPY
  } seq_st_e;
endpackage

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 5,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign cnt_o   = cnt_q;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= ptr_nxt(wp_q);
      if (do_pop)  rp_q <= ptr_nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/engine_model.sv
module engine_model #(
  parameter int BLK_W       = 12,
  parameter int CYC_PER_BLK = 11,
  localparam int CYC_W      = $clog2(CYC_PER_BLK + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] nblk_m1_i,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q;
  logic [BLK_W-1:0] blk_q;
  logic [CYC_W-1:0] cyc_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cyc_q == '0) && (blk_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      blk_q  <= '0;
      cyc_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        blk_q  <= nblk_m1_i;
        cyc_q  <= CYC_W'(CYC_PER_BLK - 1);
      end
    end else if (cyc_q != '0) begin
      cyc_q <= cyc_q - CYC_W'(1);
    end else if (blk_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      blk_q <= blk_q - BLK_W'(1);
      cyc_q <= CYC_W'(CYC_PER_BLK - 1);
    end
  end
endmodule

// File: rtl/key_slots.sv
module key_slots #(
  parameter int N       = 8,
  parameter int W       = 32,
  parameter int SECURE  = 4,
  localparam int IW     = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] slot_q [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    if (g == SECURE) begin : g_sec
      // host-side image of the secure slot is never populated
      assign slot_q[g] = '0;
    end else begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          slot_q[g] <= '0;
        else if (we_i && widx_i == IW'(g))    slot_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = slot_q[ridx_i];
endmodule

// File: rtl/crypt_cmdq_seq.sv
module crypt_cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int Q_DEPTH     = 5,
  parameter int N_SLOTS     = 8,
  parameter int SECURE_SLOT = 4,
  parameter int CYC_PER_BLK = 11,
  parameter int BLK_W       = 12,
  parameter int WCNT_LSB    = 12,
  parameter int WCNT_W      = 13,
  parameter int KID_LSB     = 17,
  localparam int SLOT_W     = $clog2(N_SLOTS),
  localparam int QC_W       = $clog2(Q_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [31:0]       cmd_wdata_i,
  input  logic              irq_clr_we_i,
  input  logic [IRQ_W-1:0]  irq_clr_i,
  input  logic              irq_en_we_i,
  input  logic [IRQ_W-1:0]  irq_en_i,
  input  logic [SLOT_W-1:0] slot_rd_idx_i,
  output logic              eng_busy_o,
  output logic              q_empty_o,
  output logic              dma_busy_o,
  output logic [IRQ_W-1:0]  irq_stat_o,
  output logic              irq_o,
  output logic [31:0]       src_addr_o,
  output logic [31:0]       slot_rd_data_o
);
  logic [31:0]       head;
  logic              q_full, q_pop;
  logic [QC_W-1:0]   q_cnt;
  logic [OPC_W-1:0]  op;
  seq_st_e           st_q;
  logic              pend_copy_q, pend_dir_q;
  logic [WCNT_W-1:0] pend_nw_q, cpy_cnt_q;
  logic [31:0]       cpy_addr_q, ram_tag_q, src_q;
  logic              eng_start, eng_done;
  logic              slot_we, set_dmac, set_sec;
  logic [SLOT_W-1:0] slot_widx;
  logic [IRQ_W-1:0]  stat_q, en_q, irq_set, irq_clr;

  cmd_fifo #(.W(32), .DEPTH(Q_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (cmd_we_i),
    .data_i  (cmd_wdata_i),
    .pop_i   (q_pop),
    .data_o  (head),
    .empty_o (q_empty_o),
    .full_o  (q_full),
    .cnt_o   (q_cnt)
  );

  engine_model #(.BLK_W(BLK_W), .CYC_PER_BLK(CYC_PER_BLK)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eng_start),
    .nblk_m1_i (head[BLK_W-1:0]),
    .busy_o    (eng_busy_o),
    .done_o    (eng_done)
  );

  key_slots #(.N(N_SLOTS), .W(32), .SECURE(SECURE_SLOT)) u_slots (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (slot_we),
    .widx_i  (slot_widx),
    .wdata_i (ram_tag_q),
    .ridx_i  (slot_rd_idx_i),
    .rdata_o (slot_rd_data_o)
  );

  assign op = head[OPC_LSB +: OPC_W];
  // address words are taken even while the engine runs; opcodes wait for idle
  assign q_pop = !q_empty_o &&
                 ((st_q == ST_IDLE && !eng_busy_o) || st_q == ST_ADDR);
  assign slot_widx = head[KID_LSB +: SLOT_W];

  always_comb begin
    eng_start = 1'b0;
    slot_we   = 1'b0;
    set_dmac  = 1'b0;
    set_sec   = 1'b0;
    if (q_pop && st_q == ST_IDLE) begin
      case (op)
        OP_START:    eng_start = 1'b1;
        OP_DMA_DONE: set_dmac  = 1'b1;
        OP_TABLE: begin
          if (head[25:24] == 2'd3) begin
            if (slot_widx == SLOT_W'(SECURE_SLOT)) set_sec = 1'b1;
            else                                  slot_we = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pend_copy_q <= 1'b0;
      pend_dir_q  <= 1'b0;
      pend_nw_q   <= '0;
      cpy_cnt_q   <= '0;
      cpy_addr_q  <= '0;
      ram_tag_q   <= '0;
      src_q       <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (q_pop && op == OP_DMA_SETUP) begin
            st_q        <= ST_ADDR;
            pend_copy_q <= 1'b0;
          end else if (q_pop && op == OP_COPY) begin
            st_q        <= ST_ADDR;
            pend_copy_q <= 1'b1;
            pend_dir_q  <= head[25];
            pend_nw_q   <= head[WCNT_LSB +: WCNT_W];
          end
        end
        ST_ADDR: begin
          if (q_pop) begin
            if (pend_copy_q) begin
              st_q       <= ST_COPY;
              cpy_cnt_q  <= pend_nw_q;
              cpy_addr_q <= head;
            end else begin
              st_q  <= ST_IDLE;
              src_q <= head;
            end
          end
        end
        ST_COPY: begin
          if (cpy_cnt_q <= WCNT_W'(1)) begin
            st_q <= ST_IDLE;
            if (!pend_dir_q) ram_tag_q <= cpy_addr_q;
          end else begin
            cpy_cnt_q <= cpy_cnt_q - WCNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_DONE] = eng_done;
    irq_set[IRQ_DMAC] = set_dmac;
    irq_set[IRQ_OVF]  = cmd_we_i && q_full;
    irq_set[IRQ_SEC]  = set_sec;
    irq_clr           = irq_clr_we_i ? irq_clr_i : '0;
  end

  // new events win over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~irq_clr) | irq_set;
      if (irq_en_we_i) en_q <= irq_en_i;
    end
  end

  assign dma_busy_o = (st_q == ST_COPY);
  assign irq_stat_o = stat_q;
  assign irq_o      = |(stat_q & en_q);
  assign src_addr_o = src_q;
endmodule

// File: rtl/crypt_cmdq_seq_chk.sv
module crypt_cmdq_seq_chk
  import cmdq_pkg::*;
#(
  parameter int Q_DEPTH     = 5,
  parameter int N_SLOTS     = 8,
  parameter int SECURE_SLOT = 4,
  localparam int SLOT_W     = $clog2(N_SLOTS),
  localparam int QC_W       = $clog2(Q_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_we_i,
  input logic              q_full,
  input logic [QC_W-1:0]   q_cnt,
  input logic              eng_busy_o,
  input logic              dma_busy_o,
  input logic [IRQ_W-1:0]  irq_stat_o,
  input logic              irq_clr_we_i,
  input logic [IRQ_W-1:0]  irq_clr_i,
  input logic              slot_we,
  input logic [SLOT_W-1:0] slot_widx
);
  logic [IRQ_W-1:0] keep_m;
  assign keep_m = irq_stat_o & ~(irq_clr_we_i ? irq_clr_i : '0);

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && q_full) |=> irq_stat_o[IRQ_OVF]);

  assert_qcnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_cnt <= QC_W'(Q_DEPTH));

  assert_done_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eng_busy_o) |-> irq_stat_o[IRQ_DONE]);

  assert_secure_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slot_we && slot_widx == SLOT_W'(SECURE_SLOT)));

  assert_busy_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eng_busy_o && dma_busy_o));

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_stat_o & $past(keep_m)) == $past(keep_m)));
endmodule

bind crypt_cmdq_seq crypt_cmdq_seq_chk #(
  .Q_DEPTH(Q_DEPTH), .N_SLOTS(N_SLOTS), .SECURE_SLOT(SECURE_SLOT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_we_i     (cmd_we_i),
  .q_full       (q_full),
  .q_cnt        (q_cnt),
  .eng_busy_o   (eng_busy_o),
  .dma_busy_o   (dma_busy_o),
  .irq_stat_o   (irq_stat_o),
  .irq_clr_we_i (irq_clr_we_i),
  .irq_clr_i    (irq_clr_i),
  .slot_we      (slot_we),
  .slot_widx    (slot_widx)
);

// File: tb/crypt_cmdq_seq_tb_top.sv
module crypt_cmdq_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wd = '0;
  logic        clr_we = 1'b0;
  logic [7:0]  clr_d = '0;
  logic        en_we = 1'b0;
  logic [7:0]  en_d = '0;
  logic [2:0]  rd_idx = '0;
  logic        eng_busy, q_empty, dma_busy, irq;
  logic [7:0]  stat;
  logic [31:0] src_addr, slot_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_slot [8];
  logic [31:0] exp_tag = '0;

  always #4 clk = ~clk;

  crypt_cmdq_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd),
    .irq_clr_we_i(clr_we), .irq_clr_i(clr_d),
    .irq_en_we_i(en_we), .irq_en_i(en_d),
    .slot_rd_idx_i(rd_idx),
    .eng_busy_o(eng_busy), .q_empty_o(q_empty), .dma_busy_o(dma_busy),
    .irq_stat_o(stat), .irq_o(irq),
    .src_addr_o(src_addr), .slot_rd_data_o(slot_data)
  );

  function automatic logic [31:0] f_start(input int n);
    return (32'h0E << 26) | (32'(n) & 32'hFFF);
  endfunction
  function automatic logic [31:0] f_setup();
    return 32'h10 << 26;
  endfunction
  function automatic logic [31:0] f_mark();
    return 32'h11 << 26;
  endfunction
  function automatic logic [31:0] f_copy(input bit dir, input int nw);
    return (32'h22 << 26) | (32'(dir) << 25) | ((32'(nw) & 32'h1FFF) << 12);
  endfunction
  function automatic logic [31:0] f_table(input int slot, input int sel);
    return (32'h15 << 26) | ((32'(sel) & 3) << 24) | (32'h1 << 23) |
           ((32'h8 | (32'(slot) & 7)) << 17);
  endfunction
  function automatic int f_busy(input int n);
    return (n + 1) * 11;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_wd = w;
    @(posedge clk);
    #1 cmd_we = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_we = 1'b1;
    clr_d  = 8'hFF;
    @(posedge clk);
    #1 clr_we = 1'b0;
  endtask

  task automatic set_en(input logic [7:0] v);
    @(negedge clk);
    en_we = 1'b1;
    en_d  = v;
    @(posedge clk);
    #1 en_we = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    repeat (3) @(negedge clk);
    while (!(q_empty && !eng_busy && !dma_busy) && t < 100000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic measure(input bit use_dma, output int c);
    int t = 0;
    logic cur;
    c = 0;
    while (t < 100000) begin
      @(negedge clk);
      cur = use_dma ? dma_busy : eng_busy;
      if (cur) c++;
      else if (c > 0) break;
      t++;
    end
  endtask

  task automatic read_slot(input int s, output logic [31:0] d);
    @(negedge clk);
    rd_idx = 3'(s);
    #1 d = slot_data;
  endtask

  task automatic copy_in(input logic [31:0] a, input int nw, output int c);
    push(f_copy(1'b0, nw));
    push(a);
    measure(1'b1, c);
    exp_tag = a;
    wait_idle();
  endtask

  initial begin
    #(8 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c;
    int n;
    int s;
    logic [31:0] a, d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) exp_slot[i] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 q_empty", 32'(q_empty), 32'd1);
    chk("R1 eng_busy", 32'(eng_busy), 32'd0);
    chk("R1 dma_busy", 32'(dma_busy), 32'd0);
    chk("R1 irq_stat", 32'(stat), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 src_addr", src_addr, 32'd0);
    read_slot(2, d);
    chk("R1 slot", d, 32'd0);

    // R2 DMA setup takes next word as address
    for (int i = 0; i < 4; i++) begin
      a = $urandom;
      push(f_setup());
      push(a);
      wait_idle();
      chk("R2 src_addr", src_addr, a);
    end

    // R3 busy length, R4 done flag
    for (int i = 0; i < 6; i++) begin
      n = (i == 0) ? 0 : $urandom_range(1, 12);
      clear_all();
      push(f_start(n));
      measure(1'b0, c);
      chk("R3 busy cycles", 32'(c), 32'(f_busy(n)));
      @(negedge clk);
      chk("R4 done bit", 32'(stat[0]), 32'd1);
    end

    // R5 enable mask and write-one-to-clear
    clear_all();
    @(negedge clk);
    chk("R5 cleared", 32'(stat), 32'd0);
    set_en(8'h00);
    push(f_start(0));
    wait_idle();
    chk("R5 masked irq", 32'(irq), 32'd0);
    set_en(8'h33);
    @(negedge clk);
    chk("R5 enabled irq", 32'(irq), 32'd1);
    clear_all();
    @(negedge clk);
    chk("R5 clear stat", 32'(stat), 32'd0);
    chk("R5 clear irq", 32'(irq), 32'd0);

    // R6 completion marker
    push(f_mark());
    wait_idle();
    chk("R6 mark bit", 32'(stat), 32'h02);
    clear_all();

    // R7/R8 inbound copy then table load
    for (int i = 0; i < 3; i++) begin
      a = $urandom;
      n = $urandom_range(1, 20);
      s = $urandom_range(0, 6);
      if (s >= 4) s++;
      copy_in(a, n, c);
      chk("R7 copy busy", 32'(c), 32'(n));
      push(f_table(s, 3));
      wait_idle();
      exp_slot[s] = exp_tag;
      read_slot(s, d);
      chk("R8 slot load", d, exp_slot[s]);
    end
    // R7 zero word count still one cycle
    a = $urandom;
    copy_in(a, 0, c);
    chk("R7 zero count busy", 32'(c), 32'd1);
    // R7 outbound copy leaves key image
    push(f_copy(1'b1, 3));
    push($urandom);
    wait_idle();
    push(f_table(7, 3));
    wait_idle();
    exp_slot[7] = exp_tag;
    read_slot(7, d);
    chk("R7 outbound keeps image", d, a);
    // R8 other table select ignored
    copy_in($urandom, 2, c);
    push(f_table(7, 2));
    wait_idle();
    read_slot(7, d);
    chk("R8 sel ignored", d, exp_slot[7]);

    // R9 secure slot refused
    clear_all();
    push(f_table(4, 3));
    wait_idle();
    chk("R9 secure err", 32'(stat), 32'h20);
    read_slot(4, d);
    chk("R9 secure reads zero", d, 32'd0);
    read_slot(7, d);
    chk("R9 other slot kept", d, exp_slot[7]);

    // R10/R11 overflow behind a long run
    clear_all();
    a = $urandom;
    d = src_addr;
    push(f_start(63));
    while (!eng_busy) @(negedge clk);
    push(f_setup());
    push(a);
    for (int i = 0; i < 4; i++) push(f_mark());
    @(negedge clk);
    chk("R10 overflow bit", 32'(stat[4]), 32'd1);
    chk("R11 queue held", 32'(q_empty), 32'd0);
    chk("R11 setup deferred", src_addr, d);
    wait_idle();
    chk("R11 setup applied", src_addr, a);
    chk("R10 marks done", 32'(stat & 8'h13), 32'h13);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule